// File: doc/BRIEF.md
# Three-Wire Nibble Register Transfer Engine

This block is a serial master that reads and writes 4-bit registers in a real-time-clock device. The link has three wires: an active-high chip-enable, a serial clock that idles high, and one bidirectional data line. The host side offers a single request: a register address, a write value and a read/write flag. When the transfer completes, the block pulses `done_o`. For a read, it also presents the returned nibble.

Each register access begins with a command byte. This byte carries the address together with marker bits. A write then sends a second byte that holds the value and a data marker. A read instead clocks in one byte from the device and keeps only its low nibble. A byte-level bit sequencer shifts every byte most significant bit first. Both halves of each serial clock period last `HALF_CYC` system clocks. The default is 175 cycles, which is 700 ns at 250 MHz. The sequencer also controls the output enable for the data pad. Chip-enable stays high for the whole transfer. It can also be held high across several transfers with `hold_i`.

Top module: `twn_xfer_top`

## Requirements
- R1: Every byte on the link is shifted most significant bit first, and the data line does not change while the serial clock is low.
- R2: The command byte puts the register address in bits 3:0, sets bit 5 and clears all other bits; bit 6 is additionally set when the access is a read.
- R3: A write is the command byte followed by a data byte with the write value in bits 3:0, bit 4 set and bits 7:5 clear.
- R4: A read is the command byte followed by eight received bits, MSB first; `rdata_o` returns bits 3:0 of the received byte and is valid from the `done_o` pulse on.
- R5: The serial clock is high whenever no transfer is running; each bit holds the clock high for `HALF_CYC` cycles and then low for exactly `HALF_CYC` cycles before it returns high.
- R6: The data output enable rises one cycle after the first bit of a transmitted byte is placed, stays high for all eight bits, and falls when the eighth bit's clock returns high; it is low for every received bit and after the transfer ends.
- R7: A received bit is taken from the data line, through a two-flop synchronizer, at the end of the clock-high half, just before the clock falls.
- R8: Chip-enable is high from the cycle after a request is accepted until `done_o`, on every bit of the transfer, and whenever `hold_i` was high in the previous cycle; otherwise it is low.
- R9: `done_o` is a one-cycle pulse, one per accepted request; requests made while a transfer is in progress are ignored and leave the transfer unchanged.
- R10: After reset, chip-enable, output enable and `done_o` are low and the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transfer (sampled only when idle) |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write value |
| hold_i | input | 1 | Keep chip-enable asserted while idle |
| rdata_o | output | 4 | Read nibble |
| done_o | output | 1 | One-cycle completion pulse |
| ce_o | output | 1 | Device chip-enable, active high |
| sclk_o | output | 1 | Serial clock, idles high |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Data pad output enable |
| sd_i | input | 1 | Serial data in |

## Verification
The bench looks at several corner cases, each of which a wrong design would show in its output:
- Addresses 0x0 and 0xF and write values 0x0 and 0xF. Marker or payload bits that are swapped or merged would corrupt the captured bytes.
- Read responses whose upper nibble is non-zero. A design that leaks the upper bits, or that samples after the clock falls, would return the wrong nibble, because the bench changes the data line right after each falling edge.
- A second request injected mid-transfer. An engine that re-latches its request would alter the frame or give an extra `done_o`.
- A transfer run with `hold_i` high, where chip-enable must stay high after completion.
- Every low clock phase is measured, and the output enable is sampled on every bit.

// File: rtl/twn_pkg.sv
`timescale 1ns/1ps
package twn_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  // marker bit positions are decoded by the device
  localparam int ADDR_MARK_BIT = 5;
  localparam int READ_MARK_BIT = 6;
  localparam int DATA_MARK_BIT = 4;

  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_LOW} seq_st_t;
  typedef enum logic [2:0] {T_IDLE, T_ADDR, T_ADDR_W, T_SECOND, T_SECOND_W} xfer_st_t;

  function automatic logic [BYTE_W-1:0] mk_cmd_byte(input logic [NIB_W-1:0] a, input logic rd);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[NIB_W-1:0] = a;
    b[ADDR_MARK_BIT] = 1'b1;
    b[READ_MARK_BIT] = rd;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] mk_data_byte(input logic [NIB_W-1:0] v);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[NIB_W-1:0] = v;
    b[DATA_MARK_BIT] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/twn_sync2.sv
`timescale 1ns/1ps
module twn_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {2{RST_VAL}};
    else         ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/twn_bit_seq.sv
`timescale 1ns/1ps
module twn_bit_seq
  import twn_pkg::*;
#(
  parameter int HALF_CYC = 175
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tx_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rx_bit_i,
  output logic              sclk_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic              done_o,
  output logic [NIB_W-1:0]  rx_low_o
);
  localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [CW-1:0] CMAX = CW'(HALF_CYC - 1);
  localparam int IW = $clog2(BYTE_W);
  localparam logic [IW-1:0] LAST_BIT = IW'(BYTE_W - 1);

  seq_st_t           st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              tx_q, sclk_q, sd_q, oe_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      tx_q   <= 1'b0;
      sclk_q <= 1'b1;
      sd_q   <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q  <= S_HIGH;
          cnt_q <= '0;
          idx_q <= '0;
          sh_q  <= byte_i;
          tx_q  <= tx_i;
          if (tx_i) sd_q <= byte_i[BYTE_W-1];
        end
        S_HIGH: begin
          oe_q <= tx_q; // enable one cycle after the bit is placed
          if (cnt_q == CMAX) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            st_q   <= S_LOW;
            if (!tx_q) sh_q <= {sh_q[BYTE_W-2:0], rx_bit_i};
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        S_LOW: begin
          if (cnt_q == CMAX) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
            if (tx_q) begin
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
              sd_q <= sh_q[BYTE_W-2];
            end
            if (idx_q == LAST_BIT) begin
              st_q   <= S_IDLE;
              oe_q   <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + IW'(1);
              st_q  <= S_HIGH;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sclk_o   = sclk_q;
  assign sd_o     = sd_q;
  assign sd_oe_o  = oe_q;
  assign done_o   = done_q;
  assign rx_low_o = sh_q[NIB_W-1:0];

  p_sd_steady_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_q && $past(!sclk_q)) |-> $stable(sd_q));

  p_oe_off_rx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE && !tx_q) |-> !oe_q);

  p_idle_clk_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE) |-> sclk_q);
endmodule

// File: rtl/twn_xfer_top.sv
`timescale 1ns/1ps
module twn_xfer_top
  import twn_pkg::*;
#(
  parameter int HALF_CYC = 175
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             rd_i,
  input  logic [NIB_W-1:0] addr_i,
  input  logic [NIB_W-1:0] wdata_i,
  input  logic             hold_i,
  output logic [NIB_W-1:0] rdata_o,
  output logic             done_o,
  output logic             ce_o,
  output logic             sclk_o,
  output logic             sd_o,
  output logic             sd_oe_o,
  input  logic             sd_i
);
  xfer_st_t          st_q, st_d;
  logic [NIB_W-1:0]  addr_q, wdata_q, rdata_q;
  logic              rd_q, done_q, ce_q;
  logic              seq_start, seq_tx, seq_done, sd_sync;
  logic [BYTE_W-1:0] seq_byte;
  logic [NIB_W-1:0]  seq_rx;
  logic              fin;

  twn_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sd_i),
    .q_o   (sd_sync)
  );

  twn_bit_seq #(.HALF_CYC(HALF_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (seq_start),
    .tx_i    (seq_tx),
    .byte_i  (seq_byte),
    .rx_bit_i(sd_sync),
    .sclk_o  (sclk_o),
    .sd_o    (sd_o),
    .sd_oe_o (sd_oe_o),
    .done_o  (seq_done),
    .rx_low_o(seq_rx)
  );

  always_comb begin
    st_d      = st_q;
    seq_start = 1'b0;
    seq_tx    = 1'b1;
    seq_byte  = mk_cmd_byte(addr_q, rd_q);
    case (st_q)
      T_IDLE:     if (req_i) st_d = T_ADDR;
      T_ADDR: begin
        seq_start = 1'b1;
        st_d      = T_ADDR_W;
      end
      T_ADDR_W:   if (seq_done) st_d = T_SECOND;
      T_SECOND: begin
        seq_start = 1'b1;
        seq_tx    = !rd_q;
        seq_byte  = mk_data_byte(wdata_q);
        st_d      = T_SECOND_W;
      end
      T_SECOND_W: if (seq_done) st_d = T_IDLE;
      default:    st_d = T_IDLE;
    endcase
  end

  assign fin = (st_q == T_SECOND_W) && seq_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= T_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      ce_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      ce_q   <= hold_i | (st_d != T_IDLE);
      if (st_q == T_IDLE && req_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        rd_q    <= rd_i;
      end
      if (fin && rd_q) rdata_q <= seq_rx;
    end
  end

  assign rdata_o = rdata_q;
  assign done_o  = done_q;
  assign ce_o    = ce_q;

  p_oe_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> ce_q);

  p_clk_idle_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_IDLE) |-> sclk_o);

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_req_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != T_IDLE) |=> ($stable(addr_q) && $stable(wdata_q) && $stable(rd_q)));

  p_ce_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_IDLE && !$past(hold_i)) |-> !ce_q);
endmodule

// File: tb/sim_twn_xfer_top.sv
`timescale 1ns/1ps
module sim_twn_xfer_top;
  localparam int HALF = 6;

  typedef struct packed {
    logic       rx;
    logic [7:0] val;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0, rd_i = 1'b0, hold_i = 1'b0;
  logic [3:0] addr_i = '0, wdata_i = '0;
  logic       sd_i;
  logic [3:0] rdata_o;
  logic       done_o, ce_o, sclk_o, sd_o, sd_oe_o;

  int total = 0;
  int bad   = 0;

  item_t      bq[$];
  logic [4:0] rq[$];

  always #2 clk = ~clk;

  twn_xfer_top #(.HALF_CYC(HALF)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req_i),
    .rd_i   (rd_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .hold_i (hold_i),
    .rdata_o(rdata_o),
    .done_o (done_o),
    .ce_o   (ce_o),
    .sclk_o (sclk_o),
    .sd_o   (sd_o),
    .sd_oe_o(sd_oe_o),
    .sd_i   (sd_i)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: queue expected link bytes and result, then issue the request
  task automatic do_xfer(input logic rd, input logic [3:0] a, input logic [3:0] wd,
                         input logic [7:0] resp, input logic poke);
    item_t it;
    it.rx  = 1'b0;
    it.val = 8'h20 | (rd ? 8'h40 : 8'h00) | {4'h0, a};
    bq.push_back(it);
    if (rd) begin
      it.rx  = 1'b1;
      it.val = resp;
    end else begin
      it.rx  = 1'b0;
      it.val = 8'h10 | {4'h0, wd};
    end
    bq.push_back(it);
    rq.push_back({rd, resp[3:0]});
    @(negedge clk);
    req_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = wd;
    @(negedge clk);
    req_i = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      req_i = 1'b1; rd_i = !rd; addr_i = ~a; wdata_i = ~wd;
      @(negedge clk);
      req_i = 1'b0;
    end
    do @(negedge clk); while (!done_o);
    @(negedge clk);
  endtask

  // monitor and device model
  initial begin
    logic       sclk_prev;
    int         nbits;
    logic [7:0] acc;
    int         low_cnt;
    logic [4:0] r;
    sclk_prev = 1'b1; nbits = 0; acc = '0; low_cnt = 0; sd_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!sclk_o) low_cnt++;
        if (sclk_prev && !sclk_o) begin
          chk(ce_o == 1'b1, "R8 ce high on bit", ce_o, 1);
          if (bq.size() == 0) begin
            chk(1'b0, "R9 unexpected bit", 0, 0);
          end else if (!bq[0].rx) begin
            chk(sd_oe_o == 1'b1, "R6 oe on tx bit", sd_oe_o, 1);
            acc = {acc[6:0], sd_o};
            nbits++;
            if (nbits == 8) begin
              chk(acc == bq[0].val, "R1/R2/R3 link byte", acc, bq[0].val);
              void'(bq.pop_front());
              nbits = 0;
              if (bq.size() > 0 && bq[0].rx) sd_i = bq[0].val[7];
            end
          end else begin
            chk(sd_oe_o == 1'b0, "R6 oe off on rx bit", sd_oe_o, 0);
            nbits++;
            if (nbits < 8) sd_i = bq[0].val[7-nbits];
            else begin
              void'(bq.pop_front());
              nbits = 0;
            end
          end
        end
        if (!sclk_prev && sclk_o) begin
          chk(low_cnt == HALF, "R5 low phase length", low_cnt, HALF);
          low_cnt = 0;
        end
        if (done_o) begin
          chk(ce_o == hold_i, "R8 ce at done", ce_o, hold_i);
          chk(sd_oe_o == 1'b0, "R6 oe off at done", sd_oe_o, 0);
          if (rq.size() == 0) chk(1'b0, "R9 extra done", 1, 0);
          else begin
            r = rq.pop_front();
            if (r[4]) chk(rdata_o == r[3:0], "R4 R7 read nibble", rdata_o, r[3:0]);
          end
        end
        sclk_prev = sclk_o;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_o == 1'b0,    "R10 ce reset",   ce_o, 0);
    chk(sclk_o == 1'b1,  "R10 sclk reset", sclk_o, 1);
    chk(sd_oe_o == 1'b0, "R10 oe reset",   sd_oe_o, 0);
    chk(done_o == 1'b0,  "R10 done reset", done_o, 0);

    hold_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_o == 1'b1, "R8 ce follows hold", ce_o, 1);
    hold_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(ce_o == 1'b0, "R8 ce idle low", ce_o, 0);

    do_xfer(1'b0, 4'h0, 4'hA, 8'h00, 1'b0);
    do_xfer(1'b0, 4'hF, 4'h5, 8'h00, 1'b0);
    do_xfer(1'b0, 4'h6, 4'hF, 8'h00, 1'b0);
    do_xfer(1'b1, 4'hE, 4'h0, 8'hB6, 1'b0);
    do_xfer(1'b1, 4'h3, 4'h0, 8'h59, 1'b0);
    do_xfer(1'b0, 4'h7, 4'h0, 8'h00, 1'b1);
    do_xfer(1'b1, 4'h1, 4'h0, 8'hC3, 1'b1);
    hold_i = 1'b1;
    do_xfer(1'b1, 4'h9, 4'h0, 8'hFF, 1'b0);
    chk(ce_o == 1'b1, "R8 ce held after done", ce_o, 1);
    chk(sclk_o == 1'b1, "R5 clock idles high", sclk_o, 1);
    hold_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(ce_o == 1'b0, "R8 ce released", ce_o, 0);

    repeat (5) @(negedge clk);
    chk(bq.size() == 0, "R9 link bytes left", bq.size(), 0);
    chk(rq.size() == 0, "R9 results left", rq.size(), 0);
    chk(done_o == 1'b0, "R9 no stray done", done_o, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule